// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This block treats a 64-bit word as a vector of independent lanes and applies one operation to every lane at once. Two lane layouts exist: eight unsigned 8-bit lanes, or four signed 16-bit lanes. The first operand always comes from `src_a`. The second operand is taken, per request, from the matching lane of `src_b`, from one lane of `src_b` copied to every lane, or from a 5-bit immediate copied to every lane.

The operations are bitwise logic, logical and arithmetic shifts, add, subtract, multiply with saturation, signed or unsigned min/max, sign transfer, absolute difference and rounding average. A few of them exist in only one lane layout. A request is taken on a cycle with `in_valid` high. One clock later the result appears with `out_valid`. If the operation is not defined for the chosen layout, the result is zero and `illegal_op` is raised.

A small output state machine handles the output side. It has three states: `ST_IDLE` (nothing presented), `ST_DONE` (legal result presented) and `ST_BAD` (illegal request presented). From any state, a request with a legal code moves to `ST_DONE` and one with an illegal code moves to `ST_BAD`. A cycle with no request returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `simd_lane_alu`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to zero and drives `out_valid` and `illegal_op` low on the next edge.
- R2: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. When no request arrives, `result` keeps its last value.
- R3: `sel_field[0]` picks the layout: 0 gives eight unsigned byte lanes, 1 gives four signed halfword lanes. Lane i occupies bits [8i+7:8i] or [16i+15:16i].
- R4: `sel_field[4:3]` picks the second operand. When bit 4 is 0, one `src_b` element is copied to all lanes. The value 10 takes the whole `src_b` vector. The value 11 takes `imm`, zero-extended and copied to all lanes, and `src_b` is then ignored.
- R5: When one element is copied, its index is `sel_field[3:2]` for halfword lanes and `sel_field[3:1]` for byte lanes.
- R6: Op codes 0, 1, 2 and 3 give AND, NOR, OR and XOR of the two operands.
- R7: Op 4 shifts left logically and op 5 shifts right logically. The count is the low 3 bits of the second operand (bytes) or the low 4 bits (halfwords). Op 12 is an arithmetic right shift for halfword lanes.
- R8: For bytes, add (op 6) and multiply (op 10) saturate at 255, and subtract (op 7) stops at 0.
- R9: For halfwords, add, subtract and multiply (ops 6, 7, 10) clamp to the range -32768 to 32767.
- R10: Min (op 8) and max (op 9) compare byte lanes as unsigned and halfword lanes as signed.
- R11: Sign transfer (op 11, halfwords only) works on each lane from the sign of `src_a`. A negative `src_a` lane gives the negated second operand, with -32768 mapping to 32767. A zero lane gives 0. A positive lane gives the second operand unchanged.
- R12: For byte lanes, op 13 gives the absolute difference and op 14 gives (a + b + 1) >> 1.
- R13: Codes 11, 12 and 15 are illegal for bytes, and codes 13, 14 and 15 are illegal for halfwords. An illegal request yields a zero `result` with `illegal_op` high for that one output cycle, together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code |
| sel_field | input | 5 | Layout bit 0, operand mode [4:3], element index [3:1]/[3:2] |
| src_a | input | 64 | First operand vector |
| src_b | input | 64 | Second operand vector or element source |
| imm | input | 5 | Immediate second operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered lane results |
| illegal_op | output | 1 | Presented request used an undefined code |

## Verification
A legal result and an illegal-op report can fall in adjacent output cycles when requests are issued back to back. Because the state machine then switches straight between `ST_DONE` and `ST_BAD` with no idle cycle in between, it must never carry the flag or the zeroing over into the neighbouring request. The bench provokes this by issuing a legal request, an illegal one and a legal one again on consecutive cycles. Each cycle's `result`, `out_valid` and `illegal_op` are then compared with a behavioural model that tracks each request separately.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_NOR = 4'd1,
        OP_OR  = 4'd2,
        OP_XOR = 4'd3,
        OP_SLL = 4'd4,
        OP_SRL = 4'd5,
        OP_ADD = 4'd6,
        OP_SUB = 4'd7,
        OP_MIN = 4'd8,
        OP_MAX = 4'd9,
        OP_MUL = 4'd10,
        OP_SGN = 4'd11,
        OP_SRA = 4'd12,
        OP_ADF = 4'd13,
        OP_AVG = 4'd14,
        OP_RSV = 4'd15
    } lane_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_BAD  = 2'd2
    } out_state_e;

    // Legal codes per layout: halfword lanes take 0..12, byte lanes take 0..10, 13, 14
    function automatic logic op_is_legal(input logic [3:0] op, input logic half_fmt);
        if (half_fmt)
            return (op <= 4'd12);
        else
            return (op <= 4'd10) || (op == 4'd13) || (op == 4'd14);
    endfunction

endpackage

// File: rtl/simd_operand_sel.sv
module simd_operand_sel #(
    parameter int VEC_W  = 64,
    parameter int LANE_W = 8,
    parameter int IMM_W  = 5,
    localparam int NLANE = VEC_W / LANE_W,
    localparam int IDX_W = $clog2(NLANE)
) (
    input  logic [VEC_W-1:0] src_b,
    input  logic [1:0]       mode,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [IMM_W-1:0] imm,
    output logic [VEC_W-1:0] opnd
);
    logic [LANE_W-1:0] elem_val;
    logic [LANE_W-1:0] imm_val;

    assign elem_val = src_b[elem_idx*LANE_W +: LANE_W];
    assign imm_val  = {{(LANE_W-IMM_W){1'b0}}, imm};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_comb begin
            if (!mode[1])
                opnd[g*LANE_W +: LANE_W] = elem_val;
            else if (!mode[0])
                opnd[g*LANE_W +: LANE_W] = src_b[g*LANE_W +: LANE_W];
            else
                opnd[g*LANE_W +: LANE_W] = imm_val;
        end
    end
endmodule

// File: rtl/simd_ulane.sv
module simd_ulane
    import simd_alu_pkg::*;
#(
    parameter int W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0]     sum;
    logic [W:0]     diff;
    logic [2*W-1:0] prod;
    logic [SH_W-1:0] sh;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign diff = {1'b0, a} - {1'b0, b};
    assign prod = a * b;
    assign sh   = b[SH_W-1:0];

    always_comb begin
        case (lane_op_e'(op))
            OP_AND: y = a & b;
            OP_NOR: y = ~(a | b);
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_SLL: y = a << sh;
            OP_SRL: y = a >> sh;
            OP_ADD: y = sum[W] ? {W{1'b1}} : sum[W-1:0];
            OP_SUB: y = diff[W] ? {W{1'b0}} : diff[W-1:0];
            OP_MIN: y = (a < b) ? a : b;
            OP_MAX: y = (a > b) ? a : b;
            OP_MUL: y = (|prod[2*W-1:W]) ? {W{1'b1}} : prod[W-1:0];
            OP_ADF: y = (a >= b) ? (a - b) : (b - a);
            OP_AVG: y = W'((sum + (W+1)'(1)) >> 1);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/simd_slane.sv
module simd_slane
    import simd_alu_pkg::*;
#(
    parameter int W = 16,
    localparam int SH_W = $clog2(W)
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

    logic [W:0]       sum;
    logic [W:0]       diff;
    logic signed [2*W-1:0] prod;
    logic [W:0]       prod_hi;
    logic [SH_W-1:0]  sh;
    logic [W-1:0]     neg_b;

    assign sum     = {a[W-1], a} + {b[W-1], b};
    assign diff    = {a[W-1], a} - {b[W-1], b};
    assign prod    = $signed(a) * $signed(b);
    assign prod_hi = prod[2*W-1:W-1];
    assign sh      = b[SH_W-1:0];
    assign neg_b   = ~b + {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        case (lane_op_e'(op))
            OP_AND: y = a & b;
            OP_NOR: y = ~(a | b);
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_SLL: y = a << sh;
            OP_SRL: y = a >> sh;
            OP_ADD: y = (sum[W] != sum[W-1]) ? (sum[W] ? S_MIN : S_MAX) : sum[W-1:0];
            OP_SUB: y = (diff[W] != diff[W-1]) ? (diff[W] ? S_MIN : S_MAX) : diff[W-1:0];
            OP_MIN: y = ($signed(a) < $signed(b)) ? a : b;
            OP_MAX: y = ($signed(a) > $signed(b)) ? a : b;
            OP_MUL: begin
                if ((prod_hi != '0) && (prod_hi != '1))
                    y = prod[2*W-1] ? S_MIN : S_MAX;
                else
                    y = prod[W-1:0];
            end
            OP_SGN: begin
                if (a[W-1])
                    y = (b == S_MIN) ? S_MAX : neg_b;
                else if (a == '0)
                    y = '0;
                else
                    y = b;
            end
            OP_SRA: y = W'($signed(a) >>> sh);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int VEC_W  = 64,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op_code,
    input  logic [4:0]       sel_field,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             illegal_op
);
    localparam int NB = VEC_W / BYTE_W;
    localparam int NH = VEC_W / HALF_W;
    localparam int BIDX_W = $clog2(NB);
    localparam int HIDX_W = $clog2(NH);

    logic [VEC_W-1:0] b_opnd, h_opnd;
    logic [VEC_W-1:0] b_res, h_res, lane_res;
    logic             half_fmt, legal;
    out_state_e       state_q, state_d;
    logic [VEC_W-1:0] result_q;

    assign half_fmt = sel_field[0];
    assign legal    = op_is_legal(op_code, half_fmt);

    simd_operand_sel #(.VEC_W(VEC_W), .LANE_W(BYTE_W), .IMM_W(IMM_W)) u_bsel (
        .src_b    (src_b),
        .mode     (sel_field[4:3]),
        .elem_idx (sel_field[BIDX_W:1]),
        .imm      (imm),
        .opnd     (b_opnd)
    );

    simd_operand_sel #(.VEC_W(VEC_W), .LANE_W(HALF_W), .IMM_W(IMM_W)) u_hsel (
        .src_b    (src_b),
        .mode     (sel_field[4:3]),
        .elem_idx (sel_field[HIDX_W+1:2]),
        .imm      (imm),
        .opnd     (h_opnd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_byte
        simd_ulane #(.W(BYTE_W)) u_lane (
            .op (op_code),
            .a  (src_a[i*BYTE_W +: BYTE_W]),
            .b  (b_opnd[i*BYTE_W +: BYTE_W]),
            .y  (b_res[i*BYTE_W +: BYTE_W])
        );
    end

    for (genvar j = 0; j < NH; j++) begin : g_half
        simd_slane #(.W(HALF_W)) u_lane (
            .op (op_code),
            .a  (src_a[j*HALF_W +: HALF_W]),
            .b  (h_opnd[j*HALF_W +: HALF_W]),
            .y  (h_res[j*HALF_W +: HALF_W])
        );
    end

    assign lane_res = half_fmt ? h_res : b_res;

    // Next-state: a request decides DONE or BAD, a quiet cycle returns to IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_BAD: begin
                if (in_valid)
                    state_d = legal ? ST_DONE : ST_BAD;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid)
                result_q <= legal ? lane_res : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_DONE: begin out_valid = 1'b1; illegal_op = 1'b0; end
            ST_BAD:  begin out_valid = 1'b1; illegal_op = 1'b1; end
            default: begin out_valid = 1'b0; illegal_op = 1'b0; end
        endcase
    end

    assign result = result_q;
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  op_code,
    input logic [4:0]  sel_field,
    input logic [63:0] src_a,
    input logic [63:0] result,
    input logic        out_valid,
    input logic        illegal_op
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (result == 64'h0 && !out_valid && !illegal_op));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    a_r13_flag_zero: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (out_valid && result == 64'h0));

    a_r13_reserved_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd15) |=> illegal_op);

    a_r8_byte_add_floor: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'd6 && !sel_field[0] && sel_field[4:3] == 2'b10)
        |=> (result[7:0] >= $past(src_a[7:0])));
endmodule

bind simd_lane_alu simd_lane_alu_chk chk_i (.*);

// File: tb/simd_lane_alu_tb_top.sv
module simd_lane_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [4:0]  sel_field = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [4:0]  imm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_op;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R1";

    logic [63:0] exp_res = '0;
    logic        exp_valid = 1'b0;
    logic        exp_ill = 1'b0;
    string       exp_tag = "R1";

    always #10 clk = ~clk;

    simd_lane_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .sel_field(sel_field), .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
    );

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [64:0] ref_calc(input int op, input logic [4:0] sel,
                                             input logic [63:0] a, input logic [63:0] b,
                                             input logic [4:0] im);
        logic [63:0] r = '0;
        int x, y, s, v;
        if (sel[0]) begin
            if (op > 12) return {1'b1, 64'h0};
            for (int i = 0; i < 4; i++) begin
                x = int'($signed(a[16*i +: 16]));
                if (!sel[4]) y = int'($signed(b[16*int'(sel[3:2]) +: 16]));
                else if (!sel[3]) y = int'($signed(b[16*i +: 16]));
                else y = int'(im);
                s = y & 15;
                case (op)
                    0: v = x & y;
                    1: v = ~(x | y);
                    2: v = x | y;
                    3: v = x ^ y;
                    4: v = (x << s) & 65535;
                    5: v = (x & 65535) >> s;
                    6: v = clampi(x + y, -32768, 32767);
                    7: v = clampi(x - y, -32768, 32767);
                    8: v = (x < y) ? x : y;
                    9: v = (x > y) ? x : y;
                    10: v = clampi(x * y, -32768, 32767);
                    11: v = (x < 0) ? ((y == -32768) ? 32767 : -y) : ((x == 0) ? 0 : y);
                    default: v = x >>> s;
                endcase
                r[16*i +: 16] = v[15:0];
            end
        end else begin
            if (op == 11 || op == 12 || op == 15) return {1'b1, 64'h0};
            for (int i = 0; i < 8; i++) begin
                x = int'(a[8*i +: 8]);
                if (!sel[4]) y = int'(b[8*int'(sel[3:1]) +: 8]);
                else if (!sel[3]) y = int'(b[8*i +: 8]);
                else y = int'(im);
                s = y & 7;
                case (op)
                    0: v = x & y;
                    1: v = ~(x | y);
                    2: v = x | y;
                    3: v = x ^ y;
                    4: v = (x << s) & 255;
                    5: v = x >> s;
                    6: v = clampi(x + y, 0, 255);
                    7: v = clampi(x - y, 0, 255);
                    8: v = (x < y) ? x : y;
                    9: v = (x > y) ? x : y;
                    10: v = clampi(x * y, 0, 255);
                    13: v = (x >= y) ? x - y : y - x;
                    default: v = (x + y + 1) / 2;
                endcase
                r[8*i +: 8] = v[7:0];
            end
        end
        return {1'b0, r};
    endfunction

    // Behavioural model advancing on each edge
    always @(posedge clk) begin
        logic [64:0] m;
        if (rst) begin
            exp_res = '0; exp_valid = 1'b0; exp_ill = 1'b0; exp_tag = "R1";
        end else if (in_valid) begin
            m = ref_calc(int'(op_code), sel_field, src_a, src_b, imm);
            exp_res = m[63:0]; exp_ill = m[64]; exp_valid = 1'b1; exp_tag = cur_tag;
        end else begin
            exp_valid = 1'b0; exp_ill = 1'b0; exp_tag = "R2";
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_tests++;
            if (result !== exp_res || out_valid !== exp_valid || illegal_op !== exp_ill) begin
                n_fail++;
                $display("FAIL %s: result=%h valid=%b ill=%b expected result=%h valid=%b ill=%b",
                         exp_tag, result, out_valid, illegal_op, exp_res, exp_valid, exp_ill);
            end
        end
    end

    task automatic issue(input int op, input logic [4:0] sel, input logic [63:0] a,
                         input logic [63:0] b, input logic [4:0] im, input string tag);
        op_code = op[3:0]; sel_field = sel; src_a = a; src_b = b; imm = im;
        cur_tag = tag; in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic quiet(input int n);
        in_valid = 1'b0;
        src_a = ~src_a; src_b = ~src_b;
        repeat (n) @(negedge clk);
    endtask

    localparam logic [4:0] BV = 5'b10000;  // byte, full vector
    localparam logic [4:0] HV = 5'b10001;  // halfword, full vector
    localparam logic [4:0] BI = 5'b11000;  // byte, immediate
    localparam logic [4:0] HI = 5'b11001;  // halfword, immediate

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        quiet(2);
        // R6 logic ops on bytes and halfwords
        issue(0, BV, 64'hF0F0_AA55_1234_FFFF, 64'h0FF0_FF00_4321_00FF, 5'd0, "R6");
        issue(1, BV, 64'hF0F0_AA55_1234_FFFF, 64'h0FF0_FF00_4321_00FF, 5'd0, "R6");
        issue(2, HV, 64'hF0F0_AA55_1234_0000, 64'h0FF0_FF00_4321_0001, 5'd0, "R6");
        issue(3, HV, 64'hF0F0_AA55_1234_0000, 64'h0FF0_FF00_4321_0001, 5'd0, "R6");
        quiet(2);
        // R3 same operands in both layouts
        issue(6, BV, 64'h7FFF_8000_00FF_0101, 64'h0001_8000_0001_FFFF, 5'd0, "R3");
        issue(6, HV, 64'h7FFF_8000_00FF_0101, 64'h0001_8000_0001_FFFF, 5'd0, "R3");
        // R4 immediate ignores src_b, element copy, full vector
        issue(6, BI, 64'h0102_0304_0506_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, "R4");
        issue(6, HI, 64'h0102_0304_7FF0_FFF0, 64'h1234_5678_9ABC_DEF0, 5'd17, "R4");
        // R5 element index: byte lane 6, halfword lane 3
        issue(2, 5'b01100, 64'h0, 64'h0011_2233_4455_6677, 5'd0, "R5");
        issue(2, 5'b01101, 64'h0, 64'hBEEF_2233_4455_6677, 5'd0, "R5");
        issue(2, 5'b00010, 64'h0, 64'h0011_2233_4455_6677, 5'd0, "R5");
        quiet(1);
        // R7 shifts with high count bits set
        issue(4, BV, 64'h8181_8181_8181_8181, 64'hF9FA_FBFC_FDFE_FFF8, 5'd0, "R7");
        issue(5, BV, 64'h8181_8181_8181_8181, 64'hF9FA_FBFC_FDFE_FFF8, 5'd0, "R7");
        issue(12, HV, 64'h8000_F00F_7FFF_8001, 64'hFFF1_0004_0014_000F, 5'd0, "R7");
        issue(5, HI, 64'h8000_F00F_7FFF_8001, 64'h0, 5'd19, "R7");
        issue(4, HI, 64'h8000_F00F_7FFF_8001, 64'h0, 5'd4, "R7");
        // R8 byte saturation
        issue(6, BV, 64'hC8C8_0000_FFFF_0A14, 64'h6464_0000_0001_1400, 5'd0, "R8");
        issue(7, BV, 64'h0A14_FF00_0102_0304, 64'h140A_0001_0201_0403, 5'd0, "R8");
        issue(10, BV, 64'h1410_0F11_FF00_0203, 64'h1410_1111_02FF_0405, 5'd0, "R8");
        // R9 halfword clamp
        issue(6, HV, 64'h7530_8AD0_0001_FFFF, 64'h2710_D8F0_0002_FFFF, 5'd0, "R9");
        issue(7, HV, 64'h8AD0_7530_8000_0005, 64'h2710_D8F0_0001_0007, 5'd0, "R9");
        issue(10, HV, 64'h012C_FED4_8000_0064, 64'h012C_012C_8000_FF9C, 5'd0, "R9");
        // R10 min/max signedness
        issue(8, BV, 64'h807F_0001_FF00_1234, 64'h7F80_0100_00FF_3412, 5'd0, "R10");
        issue(9, BV, 64'h807F_0001_FF00_1234, 64'h7F80_0100_00FF_3412, 5'd0, "R10");
        issue(8, HV, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF, 5'd0, "R10");
        issue(9, HV, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF, 5'd0, "R10");
        // R11 sign transfer
        issue(11, HV, 64'hFFFF_0000_0005_8000, 64'h8000_1234_8000_0007, 5'd0, "R11");
        issue(11, HV, 64'hFFFF_0000_0005_8000, 64'h0003_0000_FFFF_FFF0, 5'd0, "R11");
        // R12 absolute difference and average
        issue(13, BV, 64'hFF00_1020_0000_8001, 64'h00FF_2010_0000_0180, 5'd0, "R12");
        issue(14, BV, 64'hFF00_FEFF_0100_0302, 64'h00FF_FFFF_0000_0304, 5'd0, "R12");
        quiet(1);
        // R13 illegal codes, back to back with legal ones
        issue(6, BV, 64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202, 5'd0, "R13");
        issue(11, BV, 64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202, 5'd0, "R13");
        issue(6, HV, 64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202, 5'd0, "R13");
        issue(13, HV, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 5'd0, "R13");
        issue(15, BV, 64'h1, 64'h1, 5'd0, "R13");
        issue(12, BI, 64'h1, 64'h1, 5'd1, "R13");
        issue(14, HI, 64'h1, 64'h1, 5'd1, "R13");
        issue(2, BV, 64'h1, 64'h2, 5'd0, "R13");
        // R2 result held through quiet cycles
        quiet(4);
        // Sweep of all codes, layouts and operand modes
        for (int k = 0; k < 320; k++) begin
            logic [4:0] sel;
            sel = 5'($urandom);
            issue(k % 16, sel, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom), "R3");
            if (k % 7 == 0) quiet(1);
        end
        quiet(2);
        // R1 reset mid-stream
        issue(2, BV, 64'hFFFF, 64'hFFFF, 5'd0, "R1");
        rst = 1'b1;
        issue(2, BV, 64'hFFFF, 64'hFFFF, 5'd0, "R1");
        rst = 1'b0;
        quiet(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 20);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R2: watchdog expired, actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule